// File: doc/BRIEF.md
# Clock Generator Serial Configuration Slave

This block is the control port of a clock generator. A board controller reaches it over a two-wire serial bus made of a clock line and an open-drain data line. The block samples both lines with its own faster system clock and spots the start and stop conditions. It then decodes transfers aimed at its fixed device byte and updates a bank of seven eight-bit control registers. Those registers drive the generator's frequency, mode and per-output enable logic through a parallel output bus.

A write names the device and then sends two bytes that only carry framing: a command code and a byte count. The block acknowledges both and discards them. Every later byte goes into the register bank in ascending order, starting at register 0. The master may stop at any point. A read names the device with the direction bit set. The block then sends a count of its registers, followed by the registers in index order.

Top module: `clkcfg_serial_slave`

## Requirements
- R1: After reset the registers hold their power-up values and the data line is released. Register 0 (frequency and mode) is 0x00. Register 1 (processor clock enables, bits 1:0) is 0x03. Register 2 (bus clock enables, bits 6:0) is 0x7F. Register 3 (interrupt-controller and reference enables, bits 2:0) is 0x07. Registers 4 to 6 are 0x00.
- R2: A first byte of 0xD2 (write) or 0xD3 (read) is acknowledged. Any other first byte gets no acknowledge, and the block ignores every later bit until the next start.
- R3: In a write, the two bytes that follow the device byte are acknowledged and leave every register unchanged.
- R4: In a write, the third and later bytes are stored into registers 0, 1, 2 and so on, in that order. A stop after any number of them, zero included, leaves the registers that were not reached at their old values.
- R5: Write data bytes past register 6 are acknowledged and discarded.
- R6: A read returns the value 7 first, then registers 0 to 6, each most significant bit first. Any byte requested after that reads 0xFF. A master not-acknowledge ends the read.
- R7: A start or stop in the middle of a byte abandons the byte with no register change. A start begins a new device byte.
- R8: The block pulls the data line low only in its own acknowledge or read-data slots, and it changes that drive only while the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_pull_low | output | 1 | When 1, the open-drain data driver pulls the line low |
| cfg_regs | output | 56 | Register bank, register i in bits 8i+7:8i |

## Verification
The bench sends writes with zero, three and nine data bytes. A design that counted the two framing bytes as data would shift every value by two registers. One that wrapped past register 6 would overwrite register 0 or 1, and the per-clock comparison of the register bus would catch it. It sends foreign device bytes followed by traffic that would be a valid write. A block that acknowledged the wrong device, or that kept decoding after it, would then pull the line low or change a register. It cuts bytes short with a stop and with a repeated start. A design that kept its bit counter across such a condition would then misalign the next device byte and fail to acknowledge it. A read runs past the last register, so a count byte that is off by one, or a shift in the wrong direction, shows up as a wrong byte.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int          CFG_NREG  = 7;
    localparam int          IDXW      = 4;
    localparam logic [6:0]  CFG_DEV7  = 7'h69;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_RECV,
        LK_DECIDE,
        LK_ACK,
        LK_SEND,
        LK_MACK
    } link_state_t;

    typedef struct packed {
        logic            en;
        logic [IDXW-1:0] idx;
        logic [7:0]      data;
    } reg_wr_t;

    // power-up value of each control register: enables on, fields cleared
    function automatic logic [7:0] reg_default(input int i);
        case (i)
            1:       return 8'h03;
            2:       return 8'h7F;
            3:       return 8'h07;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/clkcfg_sync.sv
module clkcfg_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], d[g]};
            end
            assign q[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/clkcfg_link.sv
module clkcfg_link
    import clkcfg_pkg::*;
#(
    parameter int         NREG = CFG_NREG,
    parameter logic [6:0] DEV7 = CFG_DEV7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            scl_s,
    input  logic            sda_s,
    output logic            drv_low,
    output reg_wr_t         wr,
    output logic [IDXW-1:0] rd_idx,
    input  logic [7:0]      rd_data
);
    localparam logic [IDXW:0] NREG_W = (IDXW+1)'(NREG);

    link_state_t     state;
    logic            scl_q, sda_q;
    logic [2:0]      cnt;
    logic [7:0]      sh;
    logic            is_addr, is_read, mack_ok;
    logic [IDXW:0]   rx_num, rd_num;

    logic scl_rise, scl_fall, cond_start, cond_stop;
    logic [IDXW:0] rd_m1, dat_off;
    logic [7:0]    tx_byte;

    assign scl_rise   = scl_s & ~scl_q;
    assign scl_fall   = ~scl_s & scl_q;
    assign cond_start = scl_s & scl_q & sda_q & ~sda_s;
    assign cond_stop  = scl_s & scl_q & ~sda_q & sda_s;

    assign rd_m1   = rd_num - 1'b1;
    assign rd_idx  = rd_m1[IDXW-1:0];
    assign dat_off = rx_num - (IDXW+1)'(2);

    always_comb begin
        if (rd_num == '0)          tx_byte = 8'(NREG);
        else if (rd_num <= NREG_W) tx_byte = rd_data;
        else                       tx_byte = 8'hFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= LK_IDLE;
            scl_q   <= 1'b1;
            sda_q   <= 1'b1;
            cnt     <= '0;
            sh      <= '0;
            is_addr <= 1'b0;
            is_read <= 1'b0;
            mack_ok <= 1'b0;
            rx_num  <= '0;
            rd_num  <= '0;
            drv_low <= 1'b0;
            wr      <= '0;
        end else begin
            scl_q  <= scl_s;
            sda_q  <= sda_s;
            wr.en  <= 1'b0;
            if (cond_start) begin
                state   <= LK_RECV;
                cnt     <= '0;
                is_addr <= 1'b1;
                drv_low <= 1'b0;
            end else if (cond_stop) begin
                state   <= LK_IDLE;
                drv_low <= 1'b0;
            end else begin
                case (state)
                    LK_RECV: if (scl_rise) begin
                        sh <= {sh[6:0], sda_s};
                        if (cnt == 3'd7) begin
                            state <= LK_DECIDE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 3'd1;
                        end
                    end
                    LK_DECIDE: if (scl_fall) begin
                        if (is_addr) begin
                            if (sh[7:1] == DEV7) begin
                                drv_low <= 1'b1;
                                is_read <= sh[0];
                                is_addr <= 1'b0;
                                rx_num  <= '0;
                                rd_num  <= '0;
                                state   <= LK_ACK;
                            end else begin
                                state <= LK_IDLE;
                            end
                        end else begin
                            drv_low <= 1'b1;
                            state   <= LK_ACK;
                            if (rx_num >= (IDXW+1)'(2) && dat_off < NREG_W) begin
                                wr.en   <= 1'b1;
                                wr.idx  <= dat_off[IDXW-1:0];
                                wr.data <= sh;
                            end
                            if (rx_num != '1) rx_num <= rx_num + 1'b1;
                        end
                    end
                    LK_ACK: if (scl_fall) begin
                        cnt <= '0;
                        if (is_read) begin
                            sh      <= tx_byte;
                            drv_low <= ~tx_byte[7];
                            state   <= LK_SEND;
                            if (rd_num != '1) rd_num <= rd_num + 1'b1;
                        end else begin
                            drv_low <= 1'b0;
                            state   <= LK_RECV;
                        end
                    end
                    LK_SEND: if (scl_fall) begin
                        if (cnt == 3'd7) begin
                            drv_low <= 1'b0;
                            state   <= LK_MACK;
                        end else begin
                            drv_low <= ~sh[6];
                            sh      <= {sh[6:0], 1'b0};
                            cnt     <= cnt + 3'd1;
                        end
                    end
                    LK_MACK: begin
                        if (scl_rise) mack_ok <= ~sda_s;
                        if (scl_fall) begin
                            cnt <= '0;
                            if (mack_ok) begin
                                sh      <= tx_byte;
                                drv_low <= ~tx_byte[7];
                                state   <= LK_SEND;
                                if (rd_num != '1) rd_num <= rd_num + 1'b1;
                            end else begin
                                state <= LK_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_low) |-> !$past(scl_s)) else $error("drive raised with clock high"); // R8

    AST_STOP_IDLES: assert property (@(posedge clk) disable iff (rst)
        cond_stop |=> (state == LK_IDLE && !drv_low)) else $error("stop did not idle"); // R7

    AST_FOREIGN_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (state == LK_DECIDE && is_addr && scl_fall && sh[7:1] != DEV7)
        |=> (!drv_low && state == LK_IDLE)) else $error("foreign device acked"); // R2

    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        cond_start |=> (state == LK_RECV && cnt == 3'd0 && !drv_low)) else $error("start not honoured"); // R7
endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile
    import clkcfg_pkg::*;
#(
    parameter int NREG = CFG_NREG
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_wr_t           wr,
    input  logic [IDXW-1:0]   rd_idx,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] regs_flat
);
    logic [7:0] r [NREG];

    genvar i;
    generate
        for (i = 0; i < NREG; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    r[i] <= reg_default(i);
                else if (wr.en && wr.idx == IDXW'(i))
                    r[i] <= wr.data;
            end
            assign regs_flat[i*8 +: 8] = r[i];
        end
    endgenerate

    always_comb begin
        rd_data = 8'hFF;
        for (int k = 0; k < NREG; k++)
            if (rd_idx == IDXW'(k)) rd_data = r[k];
    end

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (wr.idx < IDXW'(NREG))) else $error("write index past bank"); // R5

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> $stable(regs_flat)) else $error("register changed without write"); // R4
endmodule

// File: rtl/clkcfg_serial_slave.sv
module clkcfg_serial_slave
    import clkcfg_pkg::*;
#(
    parameter int         NREG = CFG_NREG,
    parameter logic [6:0] DEV7 = CFG_DEV7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull_low,
    output logic [NREG*8-1:0] cfg_regs
);
    logic [1:0]      line_s;
    reg_wr_t         wr;
    logic [IDXW-1:0] rd_idx;
    logic [7:0]      rd_data;

    clkcfg_sync #(.W(2), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_in, sda_in}),
        .q   (line_s)
    );

    clkcfg_link #(.NREG(NREG), .DEV7(DEV7)) u_link (
        .clk     (clk),
        .rst     (rst),
        .scl_s   (line_s[1]),
        .sda_s   (line_s[0]),
        .drv_low (sda_pull_low),
        .wr      (wr),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    clkcfg_regfile #(.NREG(NREG)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .regs_flat (cfg_regs)
    );
endmodule

// File: tb/tb_clkcfg_serial_slave.sv
module tb_clkcfg_serial_slave;
    localparam int Q = 10;
    localparam int NR = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_pull_low;
    logic [NR*8-1:0] cfg_regs;
    logic sda_bus;

    assign sda_bus = m_sda & ~sda_pull_low;

    always #2 clk = ~clk;

    clkcfg_serial_slave dut (
        .clk          (clk),
        .rst          (rst),
        .scl_in       (m_scl),
        .sda_in       (sda_bus),
        .sda_pull_low (sda_pull_low),
        .cfg_regs     (cfg_regs)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0, run_cmp = 0, settling = 0;
    logic [7:0] mdl [NR];
    logic [7:0] exp_q [$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R4: register bus compared against the model on every clock
    always @(negedge clk) begin
        if (run_cmp && !settling && !finished)
            for (int i = 0; i < NR; i++)
                chk(cfg_regs[i*8 +: 8] == mdl[i], "R4 register bus", cfg_regs[i*8 +: 8], mdl[i]);
    end

    task automatic bit_xfer(input logic b, output logic seen);
        tick(Q); m_sda = b;
        tick(Q); m_scl = 1'b1;
        tick(Q); seen = sda_bus;
        tick(Q); m_scl = 1'b0;
    endtask

    task automatic do_start();
        tick(Q); m_sda = 1'b1;
        tick(Q); m_scl = 1'b1;
        tick(Q); m_sda = 1'b0;
        tick(Q); m_scl = 1'b0;
    endtask

    task automatic do_stop();
        tick(Q); m_sda = 1'b0;
        tick(Q); m_scl = 1'b1;
        tick(Q); m_sda = 1'b1;
        tick(2*Q);
    endtask

    // store_idx < 0: byte must not change the model
    task automatic wr_byte(input logic [7:0] b, input bit exp_ack, input int store_idx, input string req);
        logic s, a;
        for (int i = 7; i >= 0; i--) begin
            if (i == 0) settling = 1;
            bit_xfer(b[i], s);
            chk(s == b[i], "R8 no drive in master bit", s, b[i]);
        end
        if (store_idx >= 0 && store_idx < NR) mdl[store_idx] = b;
        m_sda = 1'b1;
        tick(Q); settling = 0;
        tick(Q); m_scl = 1'b1;
        tick(Q); a = sda_bus;
        tick(Q); m_scl = 1'b0;
        chk(a == !exp_ack, req, a, !exp_ack);
    endtask

    task automatic rd_byte(input bit last, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, s);
            b[i] = s;
        end
        bit_xfer(last ? 1'b1 : 1'b0, s);
    endtask

    task automatic partial(input logic [7:0] b, input int nbits);
        logic s;
        for (int i = 7; i > 7 - nbits; i--) bit_xfer(b[i], s);
    endtask

    initial begin
        logic [7:0] got;
        logic [7:0] want;
        mdl[0] = 8'h00; mdl[1] = 8'h03; mdl[2] = 8'h7F; mdl[3] = 8'h07;
        mdl[4] = 8'h00; mdl[5] = 8'h00; mdl[6] = 8'h00;
        tick(5);
        rst = 1'b0;
        tick(3);
        for (int i = 0; i < NR; i++)
            chk(cfg_regs[i*8 +: 8] == mdl[i], "R1 reset value", cfg_regs[i*8 +: 8], mdl[i]);
        chk(sda_pull_low == 1'b0, "R1 line released", sda_pull_low, 0);
        run_cmp = 1;

        // three data bytes
        do_start();
        wr_byte(8'hD2, 1, -1, "R2 write device ack");
        wr_byte(8'h55, 1, -1, "R3 command ack");
        wr_byte(8'hAA, 1, -1, "R3 count ack");
        wr_byte(8'h12, 1, 0, "R4 data ack");
        wr_byte(8'h34, 1, 1, "R4 data ack");
        wr_byte(8'h56, 1, 2, "R4 data ack");
        do_stop();

        // zero data bytes
        do_start();
        wr_byte(8'hD2, 1, -1, "R2 write device ack");
        wr_byte(8'h00, 1, -1, "R3 command ack");
        wr_byte(8'hFF, 1, -1, "R3 count ack");
        do_stop();

        // nine data bytes, two past the end
        do_start();
        wr_byte(8'hD2, 1, -1, "R2 write device ack");
        wr_byte(8'h01, 1, -1, "R3 command ack");
        wr_byte(8'h09, 1, -1, "R3 count ack");
        for (int k = 0; k < 9; k++)
            wr_byte(8'hA0 + 8'(k), 1, (k < NR) ? k : -1, k < NR ? "R4 data ack" : "R5 surplus ack");
        do_stop();

        // foreign devices
        do_start();
        wr_byte(8'hA0, 0, -1, "R2 foreign no ack");
        wr_byte(8'hD2, 0, -1, "R2 ignored after foreign");
        wr_byte(8'h5A, 0, -1, "R2 ignored after foreign");
        do_stop();
        do_start();
        wr_byte(8'hD5, 0, -1, "R2 foreign no ack");
        do_stop();

        // read back
        do_start();
        wr_byte(8'hD3, 1, -1, "R2 read device ack");
        exp_q.push_back(8'd7);
        for (int i = 0; i < NR; i++) exp_q.push_back(mdl[i]);
        exp_q.push_back(8'hFF);
        for (int k = 0; k < NR + 2; k++) begin
            rd_byte(k == NR + 1, got);
            want = exp_q.pop_front();
            chk(got == want, "R6 read byte", got, want);
        end
        do_stop();
        chk(sda_pull_low == 1'b0, "R6 released after nack", sda_pull_low, 0);

        // stop in mid-byte
        do_start();
        wr_byte(8'hD2, 1, -1, "R2 write device ack");
        wr_byte(8'h00, 1, -1, "R3 command ack");
        wr_byte(8'h00, 1, -1, "R3 count ack");
        partial(8'h3C, 4);
        do_stop();
        chk(sda_pull_low == 1'b0, "R7 idle after stop", sda_pull_low, 0);

        // start in mid-byte, then a full write
        do_start();
        wr_byte(8'hD2, 1, -1, "R2 write device ack");
        wr_byte(8'h00, 1, -1, "R3 command ack");
        partial(8'hC3, 3);
        do_start();
        wr_byte(8'hD2, 1, -1, "R7 device ack after restart");
        wr_byte(8'h00, 1, -1, "R3 command ack");
        wr_byte(8'h00, 1, -1, "R3 count ack");
        wr_byte(8'h99, 1, 0, "R7 data after restart");
        do_stop();
        tick(20);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule